// File: doc/BRIEF.md
# Merged Status Interrupt with Per-Source Acknowledge

This block folds three status events into one summary interrupt line for a network controller. The three events are a change of the link-good level, a rollover of a statistics counter, and a transmit error. Each source has its own enable bit, which software writes. When an event arrives while its enable is set, a pending flag is raised. The summary interrupt is asserted while any pending flag is set and its enable is still set.

There is no common clear. Each source is acknowledged by its own side effect. The link source clears when software writes 0 to its enable bit. The rollover source clears on any read of the counter register. The transmit-error source clears when software writes 1 to the transmit enable, or writes 0 to the transmit-error enable. A transmit error is the transmit enable dropping from 1 to 0 while transmit success is low.

The link-good input is asynchronous. It passes through a synchronizer chain followed by one more register, and the block reacts to both its rising and its falling transitions.

Top module: `stat_irq_merge`

## Requirements
- R1: During and after reset, all enable bits, all pending flags and the interrupt output read 0.
- R2: With the link enable set (`en_wdata[0]`), a rising or falling change of `link_ok_async` sets `pend_o[0]`. The flag is visible after the third rising clock edge that follows the input change, and not earlier.
- R3: A write (`en_wr`) whose `en_wdata[0]` is 0 clears `pend_o[0]` at the next edge.
- R4: With the counter enable set (`en_wdata[1]`), a `ctr_roll_pulse` sets `pend_o[1]` at the same clock edge that samples the pulse.
- R5: A `ctr_read_stb` clears `pend_o[1]` at the next edge. Writing 0 to the counter enable alone leaves `pend_o[1]` unchanged.
- R6: A transmit error sets `pend_o[2]` at the edge that samples it, when the transmit-error enable (`en_wdata[2]`) is set. A transmit error is `tx_en` high at the previous edge and low at this edge, with `tx_ok` low. None of the other seven combinations of previous `tx_en`, current `tx_en` and `tx_ok` sets the flag.
- R7: `pend_o[2]` is cleared at the next edge by `txen_set_stb`, or by a write whose `en_wdata[2]` is 0.
- R8: `irq_o` equals the OR over the three sources of (pending flag AND enable). It is combinational from registered state, so it changes at the same edge as those bits.
- R9: If an event and its own acknowledge arrive at the same edge, the pending flag is set (or stays set).
- R10: An event that arrives while its enable is 0 leaves its pending flag unchanged.
- R11: `en_q_o` shows the enable bits. A write `en_wr` loads all three bits from `en_wdata` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_ok_async | input | 1 | Link-good level, asynchronous |
| ctr_roll_pulse | input | 1 | One-cycle statistics counter rollover |
| ctr_read_stb | input | 1 | Counter register read strobe |
| tx_en | input | 1 | Current transmit-enable level |
| tx_ok | input | 1 | Transmit success level |
| txen_set_stb | input | 1 | Software writes 1 to the transmit enable |
| en_wr | input | 1 | Write strobe for the enable bits |
| en_wdata | input | 3 | Enable write data: bit 0 link, bit 1 counter, bit 2 transmit error |
| en_q_o | output | 3 | Current enable bits, same bit order |
| pend_o | output | 3 | Pending flags, same bit order |
| irq_o | output | 1 | Merged summary interrupt |

## Verification
Counter and transmit events and all acknowledges take effect at the single edge that samples them. A link change needs three edges: two synchronizer stages and the compare register. The bench drives every stimulus on a falling edge and reads outputs on the next falling edge. For a link change, it reads `pend_o[0]` after each of the first three edges, so a flag that rises one edge early or late is reported.

// File: rtl/stat_irq_pkg.sv
package stat_irq_pkg;
    localparam int unsigned NUM_SRC  = 3;
    localparam int unsigned SRC_LINK = 0;
    localparam int unsigned SRC_CTR  = 1;
    localparam int unsigned SRC_TX   = 2;
    typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/link_edge_det.sv
// Synchronizer chain plus a compare register: flags any level change.
module link_edge_det #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_async,
    output logic chg
);
    localparam int unsigned MSB = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
        logic                   last;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[MSB-1:0], lvl_async};
        st_d.last  = st_q.chain[MSB];
        chg        = st_q.chain[MSB] ^ st_q.last;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: a detected change updates the compare register at the next edge
    p_chg_consumed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        chg |=> (st_q.last != $past(st_q.last)));
endmodule

// File: rtl/pend_flag.sv
// One pending flag: set has priority over acknowledge.
module pend_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic ack,
    output logic pend
);
    typedef struct packed {
        logic flag;
    } flag_t;

    flag_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.flag = set_evt | (st_q.flag & ~ack);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.flag;

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> pend);
    // covers the acknowledge paths of R3, R5 and R7
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !set_evt) |=> !pend);
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack && !set_evt) |=> (pend == $past(pend)));
endmodule

// File: rtl/stat_irq_merge.sv
module stat_irq_merge
    import stat_irq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                link_ok_async,
    input  logic                ctr_roll_pulse,
    input  logic                ctr_read_stb,
    input  logic                tx_en,
    input  logic                tx_ok,
    input  logic                txen_set_stb,
    input  logic                en_wr,
    input  logic [NUM_SRC-1:0]  en_wdata,
    output logic [NUM_SRC-1:0]  en_q_o,
    output logic [NUM_SRC-1:0]  pend_o,
    output logic                irq_o
);
    typedef struct packed {
        src_vec_t en;
        logic     txen_prev;
    } ctl_t;

    ctl_t     st_d, st_q;
    logic     link_chg;
    src_vec_t evt, ack, set_vec, pend;

    link_edge_det #(.SYNC_STAGES(SYNC_STAGES)) i_link_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_async (link_ok_async),
        .chg       (link_chg)
    );

    always_comb begin
        st_d           = st_q;
        st_d.txen_prev = tx_en;
        if (en_wr) st_d.en = en_wdata;

        evt           = '0;
        evt[SRC_LINK] = link_chg;
        evt[SRC_CTR]  = ctr_roll_pulse;
        evt[SRC_TX]   = st_q.txen_prev & ~tx_en & ~tx_ok;

        ack           = '0;
        ack[SRC_LINK] = en_wr & ~en_wdata[SRC_LINK];
        ack[SRC_CTR]  = ctr_read_stb;
        ack[SRC_TX]   = txen_set_stb | (en_wr & ~en_wdata[SRC_TX]);

        set_vec = evt & st_q.en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        pend_flag i_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_evt (set_vec[g]),
            .ack     (ack[g]),
            .pend    (pend[g])
        );

        p_pend_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend[g]) |-> $past(st_q.en[g]));
    end

    assign en_q_o = st_q.en;
    assign pend_o = pend;
    assign irq_o  = |(pend & st_q.en);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (en_q_o == '0 && pend_o == '0 && !irq_o));
    p_irq_has_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend_o != '0 && en_q_o != '0));
    p_roll_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_roll_pulse && en_q_o[SRC_CTR]) |=> pend_o[SRC_CTR]);
    p_txerr_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q_o[SRC_TX] && $past(tx_en) && !tx_en && !tx_ok) |=> pend_o[SRC_TX]);
    p_en_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> (en_q_o == $past(en_wdata)));
endmodule

// File: tb/test_stat_irq_merge.sv
module test_stat_irq_merge;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       link_ok_async = 1'b0;
    logic       ctr_roll_pulse = 1'b0;
    logic       ctr_read_stb = 1'b0;
    logic       tx_en = 1'b0;
    logic       tx_ok = 1'b0;
    logic       txen_set_stb = 1'b0;
    logic       en_wr = 1'b0;
    logic [2:0] en_wdata = 3'b000;
    logic [2:0] en_q_o, pend_o;
    logic       irq_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stat_irq_merge i_stat_irq_merge (
        .clk(clk), .rst_n(rst_n), .link_ok_async(link_ok_async),
        .ctr_roll_pulse(ctr_roll_pulse), .ctr_read_stb(ctr_read_stb),
        .tx_en(tx_en), .tx_ok(tx_ok), .txen_set_stb(txen_set_stb),
        .en_wr(en_wr), .en_wdata(en_wdata),
        .en_q_o(en_q_o), .pend_o(pend_o), .irq_o(irq_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one edge: inputs already set on a falling edge, outputs read on the next
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle();
        ctr_roll_pulse = 0; ctr_read_stb = 0; txen_set_stb = 0; en_wr = 0;
    endtask

    task automatic wr_en(input logic [2:0] v);
        en_wr = 1; en_wdata = v; tick(); en_wr = 0;
    endtask

    initial begin
        @(negedge clk);
        tick(); tick();
        chk("R1 en", en_q_o, 0); chk("R1 pend", pend_o, 0); chk("R1 irq", irq_o, 0);
        rst_n = 1; tick();
        chk("R1 en after", en_q_o, 0); chk("R1 pend after", pend_o, 0);

        // R10: link change with enable 0
        link_ok_async = 1; repeat (4) tick();
        chk("R10 link disabled", pend_o[0], 0);

        wr_en(3'b111);
        chk("R11 en load", en_q_o, 7); chk("R8 irq idle", irq_o, 0);

        // R2: falling change, 3-edge latency
        link_ok_async = 0;
        tick(); chk("R2 fall e1", pend_o[0], 0);
        tick(); chk("R2 fall e2", pend_o[0], 0);
        tick(); chk("R2 fall e3", pend_o[0], 1);
        chk("R8 irq link", irq_o, 1);
        wr_en(3'b110);
        chk("R3 link ack", pend_o[0], 0); chk("R8 irq after ack", irq_o, 0);
        wr_en(3'b111);
        link_ok_async = 1;
        tick(); tick(); chk("R2 rise e2", pend_o[0], 0);
        tick(); chk("R2 rise e3", pend_o[0], 1);
        wr_en(3'b110); wr_en(3'b111);

        // R4, R5, R9 sweep over prior flag, enable, pulse, read
        for (int k = 0; k < 16; k++) begin
            automatic int pre = k[3], cen = k[2], pl = k[1], rd = k[0];
            automatic int exp;
            wr_en(3'b111);
            ctr_read_stb = 1; tick(); ctr_read_stb = 0;
            if (pre != 0) begin ctr_roll_pulse = 1; tick(); ctr_roll_pulse = 0; end
            wr_en({1'b1, cen[0], 1'b1});
            chk("R5 enable write keeps flag", pend_o[1], pre);
            ctr_roll_pulse = pl[0]; ctr_read_stb = rd[0]; tick(); idle();
            exp = (pl & cen) | (pre & (rd ^ 1));
            chk("R4 R5 R9 ctr flag", pend_o[1], exp);
            chk("R8 irq ctr", irq_o, exp & cen);
        end
        ctr_read_stb = 1; tick(); idle();
        wr_en(3'b111);

        // R6 sweep over previous tx_en, current tx_en, tx_ok
        for (int k = 0; k < 8; k++) begin
            automatic int pv = k[2], cu = k[1], ok = k[0];
            tx_en = pv[0]; tx_ok = 0; tick();
            txen_set_stb = 1; tick(); txen_set_stb = 0;
            chk("R7 set-stb ack", pend_o[2], 0);
            tx_en = cu[0]; tx_ok = ok[0]; tick();
            chk("R6 tx error", pend_o[2], pv & (cu ^ 1) & (ok ^ 1));
            tx_ok = 0;
        end

        // R7 clear via enable write; R9 error with ack at same edge
        tx_en = 1; tick(); tx_en = 0; tick();
        chk("R6 err again", pend_o[2], 1);
        wr_en(3'b011);
        chk("R7 en clear ack", pend_o[2], 0);
        // R10: error with enable 0
        tx_en = 1; tick(); tx_en = 0; tick();
        chk("R10 tx disabled", pend_o[2], 0);
        wr_en(3'b111);
        tx_en = 1; tick();
        tx_en = 0; txen_set_stb = 1; tick(); idle();
        chk("R9 tx err with ack", pend_o[2], 1);
        chk("R8 irq tx", irq_o, 1);
        wr_en(3'b011);
        chk("R8 irq disabled src", irq_o, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule